// File: doc/BRIEF.md
# Bus Wait-State and DMA Request-Sense Controller

This block holds one 8-bit control byte on a small I/O port and uses it in three places. A wait inserter stretches each bus cycle. When a cycle starts it loads a down-counter with the memory or I/O wait count, chosen by the cycle type, and holds a ready output low until that count runs out. The same counts apply whether the CPU or the DMA controller started the cycle. Two request-sense units take the active-low DMA request pins of channel 0 and channel 1. Each one either passes the synchronized level through or latches a falling edge until that channel's acknowledge pulse. The two mode bits for DMA channel 1 are only stored and sent out.

Control byte layout (at I/O address 0x32, all bits readable and writable): bits 7:6 set the memory wait code, bits 5:4 set the I/O wait code, bit 3 sets the request sense of channel 0, bit 2 sets the request sense of channel 1, and bits 1:0 hold the channel 1 DMA mode.

The wait inserter is a two-state machine. State W_IDLE holds ready high. State W_STALL holds ready low and counts down. Its transitions are:
- START_FREE: a start with a zero count stays in W_IDLE.
- START_STALL: a start with a non-zero count moves from W_IDLE to W_STALL and loads the counter.
- COUNT: W_STALL stays in W_STALL while the counter is above 1, decrementing it.
- FINISH: W_STALL returns to W_IDLE when the counter is 1.

Top module: `bus_wait_dreq_ctrl`

## Requirements
- R1: A write with `io_wr` high and `io_addr` equal to 0x32 stores all 8 bits of `io_wdata`. While `io_rd` is high with that address, `io_rdata` shows the stored byte. A write to any other address leaves the byte unchanged, and a read of any other address returns 0.
- R2: After reset the stored byte is 0xF0. This means 3 memory waits, 4 I/O waits, level sense on both channels and mode 00. `cyc_ready` is high and `dreq` is 0.
- R3: The memory wait code in bits 7:6 gives 0, 1, 2 or 3 wait states for the codes 00, 01, 10 and 11.
- R4: The I/O wait code in bits 5:4 gives 0, 2, 3 or 4 wait states for the codes 00, 01, 10 and 11.
- R5: A `cyc_start` pulse sampled while `cyc_ready` is high, with `cyc_io` selecting I/O (1) or memory (0), drives `cyc_ready` low for exactly N consecutive cycles after that clock edge. N is the selected wait count. When N is 0, `cyc_ready` never goes low.
- R6: A register write during a stall does not change the length of that stall. A `cyc_start` pulse during a stall is ignored.
- R7: With its sense bit at 0 (level), `dreq[i]` is the inverse of `dreq_n[i]`, delayed by a two-flop synchronizer. A change shows after two clock edges.
- R8: With its sense bit at 1 (edge), a falling edge on `dreq_n[i]` sets `dreq[i]` three clock edges later. It stays set after the pin rises again and clears at the edge that samples `dack[i]` high.
- R9: Bit 3 selects the sense of channel 0 and bit 2 selects the sense of channel 1.
- R10: `dma_mode1` always equals bits 1:0 of the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (combinational) |
| cyc_start | input | 1 | Bus cycle start pulse |
| cyc_io | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| cyc_ready | output | 1 | Low while the cycle is stalled |
| dreq_n | input | 2 | Active-low DMA request pins, channel 0 and 1 |
| dack | input | 2 | Per-channel acknowledge pulse, clears a latched request |
| dreq | output | 2 | Qualified DMA requests |
| dma_mode1 | output | 2 | Stored channel 1 DMA mode |

## Verification
Read data is combinational, so the bench samples it one time step after setting the address. A stored write shows at the first falling edge after the write's clock edge. After a start edge, `cyc_ready` is sampled at each later falling edge, and the bench counts the low samples until the first high one; that count must equal the mapped wait count. A request pin change is checked at the falling edge after the second rising edge in level mode, and after the third in edge mode, with an extra sample one edge earlier to show it has not arrived too soon.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
    typedef enum logic [0:0] {W_IDLE, W_STALL} wstate_e;

    function automatic logic [2:0] mem_waits(input logic [1:0] code);
        return {1'b0, code};
    endfunction

    function automatic logic [2:0] io_waits(input logic [1:0] code);
        return (code == 2'b00) ? 3'd0 : ({1'b0, code} + 3'd1);
    endfunction
endpackage

// File: rtl/bwd_cfg_reg.sv
module bwd_cfg_reg #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h32,
    parameter logic [7:0] RST_VAL = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic [7:0]        cfg_q
);
    logic hit;
    assign hit = (io_addr == REG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_q <= RST_VAL;
        else if (io_wr && hit)
            cfg_q <= io_wdata;
    end

    always_comb begin
        io_rdata = (io_rd && hit) ? cfg_q : 8'h00;
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && hit) |=> (cfg_q == $past(io_wdata))); // R1
    AST_OTHER_ADDR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !hit) |=> $stable(cfg_q)); // R1
endmodule

// File: rtl/bwd_wait_fsm.sv
module bwd_wait_fsm
    import bwd_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_start,
    input  logic       cyc_io,
    input  logic [1:0] mem_code,
    input  logic [1:0] io_code,
    output logic       cyc_ready
);
    wstate_e state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx, n_sel;

    always_comb begin
        n_sel = cyc_io ? CNT_W'(io_waits(io_code)) : CNT_W'(mem_waits(mem_code));
    end

    // next-state and counter
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            W_IDLE: begin
                if (cyc_start && (n_sel != '0)) begin   // START_STALL
                    state_nx = W_STALL;
                    cnt_nx   = n_sel;
                end                                     // START_FREE: stay
            end
            W_STALL: begin
                if (cnt > CNT_W'(1)) begin              // COUNT
                    cnt_nx = cnt - CNT_W'(1);
                end else begin                          // FINISH
                    state_nx = W_IDLE;
                    cnt_nx   = '0;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= W_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            W_IDLE:  cyc_ready = 1'b1;
            W_STALL: cyc_ready = 1'b0;
        endcase
    end

    AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == W_STALL) |-> (cnt != '0 && cnt <= CNT_W'(4))); // R5
    AST_START_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_ready && cyc_start && n_sel != '0) |=> !cyc_ready); // R5
    AST_ZERO_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_ready && cyc_start && n_sel == '0) |=> cyc_ready); // R5
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_ready && cnt > CNT_W'(1)) |=> (!cyc_ready && cnt == $past(cnt) - CNT_W'(1))); // R6
endmodule

// File: rtl/bwd_req_sense.sv
module bwd_req_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_pin,
    input  logic edge_mode,
    input  logic ack,
    output logic req
);
    logic [SYNC_STAGES-1:0] sh;
    logic s, s_prev, fall, pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[SYNC_STAGES-2:0], req_n_pin};
    end

    assign s    = sh[SYNC_STAGES-1];
    assign fall = s_prev && !s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_prev  <= 1'b1;
            pending <= 1'b0;
        end else begin
            s_prev <= s;
            if (!edge_mode)  pending <= 1'b0;
            else if (fall)   pending <= 1'b1;
            else if (ack)    pending <= 1'b0;
        end
    end

    assign req = edge_mode ? pending : !s;

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && fall) |=> (req || !edge_mode)); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && ack && !fall) |=> (!req || !edge_mode)); // R8
endmodule

// File: rtl/bus_wait_dreq_ctrl.sv
module bus_wait_dreq_ctrl #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h32,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic              cyc_start,
    input  logic              cyc_io,
    output logic              cyc_ready,
    input  logic [1:0]        dreq_n,
    input  logic [1:0]        dack,
    output logic [1:0]        dreq,
    output logic [1:0]        dma_mode1
);
    localparam int N_CH = 2;
    localparam int SENSE_MSB = 3;

    logic [7:0] cfg_q;

    bwd_cfg_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .RST_VAL(8'hF0)) u_cfg (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_q(cfg_q)
    );

    bwd_wait_fsm #(.CNT_W(CNT_W)) u_wait (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_io(cyc_io),
        .mem_code(cfg_q[7:6]), .io_code(cfg_q[5:4]), .cyc_ready(cyc_ready)
    );

    // channel 0 sense from bit 3, channel 1 from bit 2 (crossed order)
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        bwd_req_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
            .clk(clk), .rst_n(rst_n), .req_n_pin(dreq_n[ch]),
            .edge_mode(cfg_q[SENSE_MSB-ch]), .ack(dack[ch]), .req(dreq[ch])
        );
    end

    assign dma_mode1 = cfg_q[1:0];

    AST_MODE_EXPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == REG_ADDR) |=> (dma_mode1 == $past(io_wdata[1:0]))); // R10
endmodule

// File: tb/sim_bus_wait_dreq_ctrl.sv
module sim_bus_wait_dreq_ctrl;
    logic clk = 0, rst_n = 0;
    logic [7:0] io_addr = 0, io_wdata = 0, io_rdata;
    logic io_wr = 0, io_rd = 0, cyc_start = 0, cyc_io = 0, cyc_ready;
    logic [1:0] dreq_n = 2'b11, dack = 0, dreq, dma_mode1;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    bus_wait_dreq_ctrl u0 (.*);

    task automatic chk(input string r, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
        @(negedge clk); io_wr = 0; io_addr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); io_addr = a; io_rd = 1; #1; d = io_rdata;
        io_rd = 0; io_addr = 0;
    endtask

    // start a cycle, optionally write 0x00 and re-pulse start during the stall
    task automatic run_cyc(input logic io, input bit disturb, output int lows);
        @(negedge clk); cyc_start = 1; cyc_io = io;
        @(negedge clk); cyc_start = 0;
        lows = 0;
        while (cyc_ready == 0 && lows < 12) begin
            lows++;
            if (disturb && lows == 1) begin
                io_addr = 8'h32; io_wdata = 8'h00; io_wr = 1; cyc_start = 1;
            end else begin
                io_wr = 0; cyc_start = 0;
            end
            @(negedge clk);
        end
        io_wr = 0; cyc_start = 0;
    endtask

    initial begin
        #150000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int lows;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R2 reset state
        rd(8'h32, d); chk("R2 reset byte", d, 8'hF0);
        chk("R2 ready", cyc_ready, 1);
        chk("R2 dreq", dreq, 0);
        chk("R2 mode", dma_mode1, 0);
        run_cyc(0, 0, lows); chk("R2 reset mem waits", lows, 3);
        run_cyc(1, 0, lows); chk("R2 reset io waits", lows, 4);
        // R1 readback, other address
        for (int v = 0; v < 256; v += 37) begin
            wr(8'h32, 8'(v)); rd(8'h32, d); chk("R1 readback", d, v);
            chk("R10 mode export", dma_mode1, v & 3);
        end
        wr(8'h32, 8'h5A); wr(8'h33, 8'hFF); wr(8'h12, 8'h00);
        rd(8'h32, d); chk("R1 other addr write ignored", d, 8'h5A);
        rd(8'h31, d); chk("R1 other addr reads 0", d, 0);
        // R3/R4/R5 sweep of all codes
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 4; i++) begin
                wr(8'h32, 8'((m << 6) | (i << 4)));
                run_cyc(0, 0, lows); chk("R3 R5 mem waits", lows, m);
                run_cyc(1, 0, lows); chk("R4 R5 io waits", lows, (i == 0) ? 0 : i + 1);
            end
        end
        // R6 write and start during a stall
        wr(8'h32, 8'hF0);
        run_cyc(0, 1, lows); chk("R6 mem stall unchanged", lows, 3);
        @(negedge clk); chk("R6 no restart", cyc_ready, 1);
        rd(8'h32, d); chk("R6 write during stall stored", d, 0);
        run_cyc(0, 0, lows); chk("R6 next cycle uses new", lows, 0);
        wr(8'h32, 8'hF0);
        run_cyc(1, 1, lows); chk("R6 io stall unchanged", lows, 4);
        // R7 level mode, both channels
        wr(8'h32, 8'h00);
        @(negedge clk); dreq_n = 2'b00;
        @(negedge clk); chk("R7 level not yet", dreq, 0);
        @(negedge clk); chk("R7 level asserted", dreq, 3);
        dreq_n = 2'b11;
        @(negedge clk); chk("R7 level held one edge", dreq, 3);
        @(negedge clk); chk("R7 level released", dreq, 0);
        // R8/R9 channel 0 edge (bit 3), channel 1 level
        wr(8'h32, 8'h08);
        @(negedge clk); dreq_n = 2'b00;
        @(negedge clk);
        @(negedge clk); chk("R9 ch1 level ch0 not yet", dreq, 2);
        @(negedge clk); chk("R8 R9 ch0 edge latched", dreq, 3);
        dreq_n = 2'b11;
        repeat (3) @(negedge clk); chk("R8 R9 ch0 held, ch1 dropped", dreq, 1);
        dack = 2'b10;
        @(negedge clk); dack = 0; chk("R9 wrong ack no clear", dreq, 1);
        dack = 2'b01;
        @(negedge clk); dack = 0; chk("R8 ack clears", dreq, 0);
        // R9 channel 1 edge (bit 2), channel 0 level
        wr(8'h32, 8'h04);
        @(negedge clk); dreq_n = 2'b00;
        repeat (3) @(negedge clk); chk("R9 ch1 edge, ch0 level", dreq, 3);
        dreq_n = 2'b11;
        repeat (3) @(negedge clk); chk("R9 ch1 held", dreq, 2);
        dack = 2'b10;
        @(negedge clk); dack = 0; chk("R8 ch1 ack clears", dreq, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule